// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores incoming frames in a circular receive area of a local byte-wide RAM. The area is made of 256-byte pages, bounded by a first page and a stop page; the stop page itself is outside the area. A current-page register marks where the next frame goes. A boundary page, owned by the host, marks how far the host has read.

For each frame the block is given a descriptor with the byte count and the group bit of the destination address. It then checks that there is room and that reception is not halted. It writes a four-byte header and the frame bytes, zero-padding short frames, and wraps to the first page when the write address reaches the stop page. When the frame is complete it moves the current page forward and raises a sticky receive interrupt request. A frame that cannot be stored is still drained from the byte stream, but nothing is written to RAM.

Top module: `rxr_top`

## Requirements
- R1: After reset the block is idle (`busy`=0, `frm_ready`=1), `cur_page`=0, `rx_irq`=0, `drop`=0, and no RAM write is issued.
- R2: Free space is computed in bytes from the current page C, the boundary page B, the first page S and the stop page E. It is 256·(B−C) when C<B, and 256·((E−S)−(C−B)) otherwise. A frame offered while free space is below 1518 bytes is refused: `drop` pulses high for one cycle in the cycle after the descriptor is taken, its bytes are consumed with no RAM write, and `cur_page` and `rx_irq` stay unchanged.
- R3: A frame offered while `cfg_halt`=1 is refused in the same way, with no RAM write and no `drop` pulse.
- R4: The header goes to addresses 256·C+0..3. Byte 0 is the status: bit 0 is always 1, bit 5 equals `frm_group`, and all other bits are 0. Byte 1 is the next page. Byte 2 is the low byte of the stored length and byte 3 is its high byte.
- R5: The stored length L is max(N,60)+4 for an N-byte frame. The next page is C+⌊(L+4+255)/256⌋; when that is ≥E, (E−S) is subtracted from it.
- R6: Frame byte k is written at address 256·C+4+k. When an address would equal 256·E, writing continues at 256·S. Every write lies in [256·S, 256·E).
- R7: Frames shorter than 60 bytes are followed by zero bytes written at the next ring addresses, until 60 bytes have been stored.
- R8: When the last byte of a frame is written, `cur_page` takes the next page and `rx_irq` becomes 1 on the following cycle. `rx_irq` stays set until `irq_clr`, and a frame completion wins over a clear.
- R9: `s_ready` is low while the header is written. Frame bytes are taken one per cycle on `s_valid`&`s_ready`, and `s_ready` is never high while the block is idle.
- R10: `cur_wr` loads `cur_wdata` into `cur_page` only while the block is idle and no descriptor is offered. A `cur_wr` during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start_pg | input | PAGE_W | First page of the ring |
| cfg_stop_pg | input | PAGE_W | Page just past the ring |
| cfg_halt | input | 1 | Reception halted; frames are refused |
| host_bnd_pg | input | PAGE_W | Host read boundary page |
| cur_wr | input | 1 | Host load strobe for the current page |
| cur_wdata | input | PAGE_W | Value for the current page |
| cur_page | output | PAGE_W | Current write page |
| irq_clr | input | 1 | Clears the receive interrupt request |
| rx_irq | output | 1 | Sticky receive-complete request |
| frm_valid | input | 1 | Frame descriptor offered |
| frm_len | input | LEN_W | Frame byte count |
| frm_group | input | 1 | Destination group bit of the frame |
| frm_ready | output | 1 | Descriptor taken (block idle) |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_ready | output | 1 | Frame byte accepted |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | PAGE_W+8 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| busy | output | 1 | A frame is being stored or drained |
| drop | output | 1 | One-cycle pulse on refusal for lack of space |

## Verification
On every cycle the assertions check the following. Writes stay inside the ring and never occur while idle. The byte stream is only opened during a frame. The current page holds still during a frame except at its completion. Each completion leaves the interrupt request raised, and a drop pulse only follows an idle cycle. Only the bench's scenarios can show that the header bytes, the padding, the wrap point and the next-page value are correct. The same holds for the exact space threshold (six free pages accepted, four refused) and for the silence of halted and refused frames. It compares every RAM write against an independently computed address and byte list.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_PAD,
    ST_DISC
  } rxr_state_e;

  // bytes free in the ring, page granular
  function automatic logic [23:0] ring_free(logic [15:0] cur, logic [15:0] bnd,
                                            logic [15:0] sp, logic [15:0] ep);
    logic [15:0] pg;
    if (cur < bnd) pg = bnd - cur;
    else           pg = (ep - sp) - (cur - bnd);
    return {pg, 8'h00};
  endfunction

  // length recorded in the header: padded size plus header
  function automatic logic [15:0] stored_len(logic [15:0] len, logic [15:0] min_len);
    logic [15:0] body;
    body = (len < min_len) ? min_len : len;
    return body + 16'd4;
  endfunction

  // page following this frame, folded back into the ring
  function automatic logic [15:0] next_page(logic [15:0] cur, logic [15:0] slen,
                                            logic [15:0] sp, logic [15:0] ep);
    logic [15:0] n;
    n = cur + ((slen + 16'd259) >> 8);
    if (n >= ep) n = n - (ep - sp);
    return n;
  endfunction

endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
  parameter int PAGE_W = 8,
  parameter int LIMIT  = 1518
) (
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  output logic              full
);
  import rxr_pkg::*;

  always_comb begin
    full = ring_free(16'(cur_pg), 16'(bnd_pg), 16'(start_pg), 16'(stop_pg)) < 24'(LIMIT);
  end
endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen #(
  parameter int PAGE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [PAGE_W-1:0]   load_pg,
  input  logic                step,
  input  logic [PAGE_W-1:0]   start_pg,
  input  logic [PAGE_W-1:0]   stop_pg,
  output logic [PAGE_W+7:0]   addr
);
  logic [PAGE_W+7:0] addr_inc;
  logic              at_wrap;

  always_comb begin
    addr_inc = addr + 1'b1;
    at_wrap  = (addr_inc == {stop_pg, 8'h00});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= {load_pg, 8'h00};
    else if (step)    addr <= at_wrap ? {start_pg, 8'h00} : addr_inc;
  end
endmodule

// File: rtl/rxr_top.sv
module rxr_top #(
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 60,
  parameter int MAX_FRAME = 1514
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_start_pg,
  input  logic [PAGE_W-1:0] cfg_stop_pg,
  input  logic              cfg_halt,
  input  logic [PAGE_W-1:0] host_bnd_pg,
  input  logic              cur_wr,
  input  logic [PAGE_W-1:0] cur_wdata,
  output logic [PAGE_W-1:0] cur_page,
  input  logic              irq_clr,
  output logic              rx_irq,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              frm_group,
  output logic              frm_ready,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  output logic              ram_we,
  output logic [PAGE_W+7:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              busy,
  output logic              drop
);
  import rxr_pkg::*;

  localparam int FULL_LIMIT = MAX_FRAME + 4;
  localparam logic [LEN_W-1:0] PAD_LAST = LEN_W'(MIN_FRAME - 1);
  localparam logic [1:0] HDR_LAST = 2'd3;

  rxr_state_e        state;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        hdr_idx;
  logic [15:0]       slen_q;
  logic [PAGE_W-1:0] nxt_q;
  logic              grp_q;
  logic [PAGE_W-1:0] cur_q;
  logic              irq_q;
  logic              drop_q;

  // named internal events
  logic ring_full;
  logic frame_take;
  logic accept_ok;
  logic refuse_full;
  logic data_beat;
  logic last_rx;
  logic pad_last;
  logic frame_done;
  logic wr_step;
  logic [7:0] hdr_byte;

  rxr_space_chk #(.PAGE_W(PAGE_W), .LIMIT(FULL_LIMIT)) u_space (
    .cur_pg   (cur_q),
    .bnd_pg   (host_bnd_pg),
    .start_pg (cfg_start_pg),
    .stop_pg  (cfg_stop_pg),
    .full     (ring_full)
  );

  always_comb begin
    frame_take  = frm_valid && (state == ST_IDLE);
    accept_ok   = !cfg_halt && !ring_full;
    refuse_full = !cfg_halt && ring_full;
    data_beat   = (state == ST_DATA) && s_valid;
    last_rx     = data_beat && (cnt == len_q - LEN_W'(1));
    pad_last    = (state == ST_PAD) && (cnt == PAD_LAST);
    frame_done  = (last_rx && (len_q >= LEN_W'(MIN_FRAME))) || pad_last;
    wr_step     = (state == ST_HDR) || data_beat || (state == ST_PAD);
    case (hdr_idx)
      2'd0:    hdr_byte = {2'b00, grp_q, 4'b0000, 1'b1};
      2'd1:    hdr_byte = 8'(nxt_q);
      2'd2:    hdr_byte = slen_q[7:0];
      default: hdr_byte = slen_q[15:8];
    endcase
  end

  rxr_addr_gen #(.PAGE_W(PAGE_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_take && accept_ok),
    .load_pg  (cur_q),
    .step     (wr_step),
    .start_pg (cfg_start_pg),
    .stop_pg  (cfg_stop_pg),
    .addr     (ram_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      len_q   <= '0;
      hdr_idx <= '0;
      slen_q  <= '0;
      nxt_q   <= '0;
      grp_q   <= 1'b0;
      cur_q   <= '0;
      irq_q   <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      drop_q <= frame_take && refuse_full;
      case (state)
        ST_IDLE: if (frame_take) begin
          len_q   <= frm_len;
          grp_q   <= frm_group;
          slen_q  <= stored_len(16'(frm_len), 16'(MIN_FRAME));
          nxt_q   <= PAGE_W'(next_page(16'(cur_q),
                                       stored_len(16'(frm_len), 16'(MIN_FRAME)),
                                       16'(cfg_start_pg), 16'(cfg_stop_pg)));
          cnt     <= '0;
          hdr_idx <= '0;
          if (accept_ok)            state <= ST_HDR;
          else if (frm_len != '0)   state <= ST_DISC;
        end
        ST_HDR: begin
          hdr_idx <= hdr_idx + 2'd1;
          if (hdr_idx == HDR_LAST) state <= (len_q == '0) ? ST_PAD : ST_DATA;
        end
        ST_DATA: if (s_valid) begin
          cnt <= cnt + LEN_W'(1);
          if (last_rx) state <= (len_q < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_IDLE;
        end
        ST_PAD: begin
          cnt <= cnt + LEN_W'(1);
          if (pad_last) state <= ST_IDLE;
        end
        ST_DISC: if (s_valid) begin
          cnt <= cnt + LEN_W'(1);
          if (cnt == len_q - LEN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (frame_done)
        cur_q <= nxt_q;
      else if (cur_wr && (state == ST_IDLE) && !frm_valid)
        cur_q <= cur_wdata;
      if (frame_done)   irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    frm_ready = (state == ST_IDLE);
    s_ready   = (state == ST_DATA) || (state == ST_DISC);
    busy      = (state != ST_IDLE);
    ram_we    = wr_step;
    ram_wdata = (state == ST_HDR)  ? hdr_byte :
                (state == ST_DATA) ? s_data   : 8'h00;
    cur_page  = cur_q;
    rx_irq    = irq_q;
    drop      = drop_q;
  end
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ram_we,
  input logic [PAGE_W+7:0] ram_addr,
  input logic              s_ready,
  input logic              frm_ready,
  input logic              drop,
  input logic              rx_irq,
  input logic [PAGE_W-1:0] cur_page,
  input logic [PAGE_W-1:0] cfg_start_pg,
  input logic [PAGE_W-1:0] cfg_stop_pg,
  input logic              frame_done
);
  a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_we);

  a_r6_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_addr >= {cfg_start_pg, 8'h00}) && (ram_addr < {cfg_stop_pg, 8'h00})));

  a_r9_ready_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);

  a_r8_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_irq);

  a_r10_page_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> $stable(cur_page));

  a_r2_drop_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> $past(frm_ready));
endmodule

bind rxr_top rxr_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .ram_we       (ram_we),
  .ram_addr     (ram_addr),
  .s_ready      (s_ready),
  .frm_ready    (frm_ready),
  .drop         (drop),
  .rx_irq       (rx_irq),
  .cur_page     (cur_page),
  .cfg_start_pg (cfg_start_pg),
  .cfg_stop_pg  (cfg_stop_pg),
  .frame_done   (frame_done)
);

// File: tb/rxr_top_test.sv
module rxr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_start_pg = 8'h40;
  logic [7:0]  cfg_stop_pg = 8'h60;
  logic        cfg_halt = 1'b0;
  logic [7:0]  host_bnd_pg = 8'h40;
  logic        cur_wr = 1'b0;
  logic [7:0]  cur_wdata = 8'h00;
  logic [7:0]  cur_page;
  logic        irq_clr = 1'b0;
  logic        rx_irq;
  logic        frm_valid = 1'b0;
  logic [10:0] frm_len = '0;
  logic        frm_group = 1'b0;
  logic        frm_ready;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_ready;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        busy;
  logic        drop;

  always #4 clk = ~clk;

  rxr_top uut (.*);

  typedef struct {
    logic [15:0] a;
    logic [7:0]  d;
    string       req;
  } wr_t;

  wr_t exp_q[$];
  int  total = 0;
  int  bad = 0;
  int  drops = 0;
  bit  finished = 0;
  int  m_cur = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: every RAM write is popped and compared
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R3", "unexpected RAM write addr", int'(ram_addr), 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check(ram_addr == e.a, e.req, "write address", int'(ram_addr), int'(e.a));
        check(ram_wdata == e.d, e.req, "write data", int'(ram_wdata), int'(e.d));
        if (e.req == "R4")
          check(s_ready == 1'b0, "R9", "s_ready during header", int'(s_ready), 0);
      end
    end
  end

  always @(negedge clk) if (rst_n && drop) drops++;

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed + i * 13) & 255);
  endfunction

  task automatic set_cur(int v);
    @(posedge clk); #1;
    cur_wr = 1'b1; cur_wdata = 8'(v);
    @(posedge clk); #1;
    cur_wr = 1'b0;
    @(negedge clk);
    check(cur_page == 8'(v), "R10", "host load of current page", int'(cur_page), v);
    m_cur = v;
  endtask

  task automatic send_frame(int len, bit grp, int seed);
    int  sp, ep, bnd, freeb, slen, nxt, body, a, d0;
    bit  take;
    sp = int'(cfg_start_pg); ep = int'(cfg_stop_pg); bnd = int'(host_bnd_pg);
    if (m_cur < bnd) freeb = 256 * (bnd - m_cur);
    else             freeb = 256 * (ep - sp) - 256 * (m_cur - bnd);
    take = !cfg_halt && (freeb >= 1518);
    body = (len < 60) ? 60 : len;
    slen = body + 4;
    nxt  = m_cur + (slen + 4 + 255) / 256;
    if (nxt >= ep) nxt = nxt - (ep - sp);
    d0 = drops;
    if (take) begin
      exp_q.push_back('{16'(m_cur * 256),     8'(grp ? 8'h21 : 8'h01), "R4"});
      exp_q.push_back('{16'(m_cur * 256 + 1), 8'(nxt),                 "R4"});
      exp_q.push_back('{16'(m_cur * 256 + 2), 8'(slen % 256),          "R4"});
      exp_q.push_back('{16'(m_cur * 256 + 3), 8'(slen / 256),          "R4"});
      a = m_cur * 256 + 4;
      for (int i = 0; i < body; i++) begin
        exp_q.push_back('{16'(a), (i < len) ? pat(seed, i) : 8'h00,
                          (i < len) ? "R6" : "R7"});
        a++;
        if (a == ep * 256) a = sp * 256;
      end
    end
    @(posedge clk); #1;
    frm_valid = 1'b1; frm_len = 11'(len); frm_group = grp;
    @(negedge clk);
    while (!frm_ready) @(negedge clk);
    @(posedge clk); #1;
    frm_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      s_valid = 1'b1; s_data = pat(seed, i);
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    s_valid = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R6", "writes outstanding", exp_q.size(), 0);
    if (take) begin
      check(cur_page == 8'(nxt), "R5", "next page", int'(cur_page), nxt);
      check(rx_irq == 1'b1, "R8", "rx_irq after frame", int'(rx_irq), 1);
      check(drops == d0, "R2", "no drop on stored frame", drops - d0, 0);
      m_cur = nxt;
    end else begin
      check(cur_page == 8'(m_cur), cfg_halt ? "R3" : "R2",
            "current page after refusal", int'(cur_page), m_cur);
      check(drops - d0 == (cfg_halt ? 0 : 1), cfg_halt ? "R3" : "R2",
            "drop pulses", drops - d0, cfg_halt ? 0 : 1);
    end
  endtask

  task automatic clear_irq();
    @(posedge clk); #1; irq_clr = 1'b1;
    @(posedge clk); #1; irq_clr = 1'b0;
    @(negedge clk);
    check(rx_irq == 1'b0, "R8", "rx_irq cleared", int'(rx_irq), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(frm_ready == 1'b1, "R1", "frm_ready after reset", int'(frm_ready), 1);
    check(cur_page == 8'h00, "R1", "cur_page after reset", int'(cur_page), 0);
    check(rx_irq == 1'b0, "R1", "rx_irq after reset", int'(rx_irq), 0);
    check(ram_we == 1'b0, "R1", "ram_we in reset", int'(ram_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(drop == 1'b0 && s_ready == 1'b0, "R1", "drop/s_ready idle",
          int'({drop, s_ready}), 0);

    set_cur(8'h40);
    send_frame(100, 1'b0, 5);          // R4 R5 R6 plain unicast
    clear_irq();
    send_frame(20, 1'b1, 77);          // R7 padding, group status bit
    // R10: host write during a frame is ignored
    fork
      send_frame(600, 1'b0, 200);
      begin
        repeat (10) @(posedge clk);
        #2 cur_wr = 1'b1; cur_wdata = 8'h55;
        @(posedge clk);
        #2 cur_wr = 1'b0;
      end
    join
    // R6 wrap at stop page, R5 fold of next page
    host_bnd_pg = 8'h50;
    set_cur(8'h5E);
    send_frame(1000, 1'b1, 9);
    // R2 boundary: exactly six free pages accepts a maximal frame
    host_bnd_pg = 8'h48;
    set_cur(8'h42);
    send_frame(1514, 1'b0, 31);
    // R2 four free pages: refused with drop
    host_bnd_pg = 8'h4C;
    clear_irq();
    send_frame(80, 1'b0, 3);
    check(rx_irq == 1'b0, "R2", "rx_irq after refusal", int'(rx_irq), 0);
    // R3 halted: refused silently
    host_bnd_pg = 8'h40;
    cfg_halt = 1'b1;
    send_frame(70, 1'b1, 4);
    cfg_halt = 1'b0;
    // exact minimum size, no padding
    send_frame(60, 1'b0, 150);
    clear_irq();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule